// File: doc/BRIEF.md
# Buffered Peripheral Write Handshake Port

This block is the outgoing device side of an I/O module. Software writes data words into it at full system speed. A small FIFO holds them. A control sequencer then hands each word to a slow peripheral over a parallel data link, using a four-phase dialog:

1. The port raises a request asking for permission to send.
2. The peripheral grants it.
3. The port drives the word and marks it valid.
4. The peripheral acknowledges receipt.

The port then withdraws its request. It waits until both peripheral lines are low before it begins the next word.

A four-bit status word lets the processor poll the port before it writes, in programmed I/O style. The bits are:

- space available
- a sticky overflow flag for writes that were lost
- a sticky timeout flag for a peripheral that stopped responding
- a drained flag

A programmable cycle limit bounds every wait on the peripheral. When a wait runs out, the port abandons that phase of the dialog rather than hanging.

Top module: `periph_wr_port`

## Requirements
- R1: After reset `devReq` and `devValid` are low and `status` reads 4'b1001 (bit0 space available, bit3 drained, bit1 and bit2 clear).
- R2: When the buffer holds a word and no transfer is in progress, `devReq` rises. `devValid` is only ever high while `devReq` is high, and it rises only in the cycle after `devGrant` was sampled high.
- R3: Each word appears on `devData` no later than the cycle `devValid` rises. It is held stable while `devValid` stays high. Words leave in the order they were written.
- R4: Once `devDone` is sampled high during the data phase, `devReq` and `devValid` fall together. `devReq` does not rise again until `devGrant` and `devDone` have both been seen low.
- R5: The buffer holds `DEPTH` (4) words. It accepts one write per cycle independent of the peripheral. `status` bit0 is high exactly when the buffer is not full.
- R6: A write while `status` bit0 is low is discarded. It also sets `status` bit1 (overflow), which stays set until cleared.
- R7: With `toLimit` nonzero, a wait for grant, receipt or release that lasts `toLimit` cycles does three things. It sets sticky `status` bit2 and withdraws `devReq`. A word still waiting for its grant stays buffered and is retried. A word already in its data phase is discarded. With `toLimit` zero no timeout occurs.
- R8: A one-cycle `stsClr` clears `status` bit1 and bit2. If a new overflow or timeout occurs in the same cycle, that new event wins and the bit stays set.
- R9: `status` bit3 is high exactly when the buffer is empty and no handshake is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Processor write strobe |
| wrData | input | DATA_W | Word to queue |
| stsClr | input | 1 | Clear the sticky status bits |
| toLimit | input | TO_W | Wait limit in cycles, 0 disables |
| status | output | 4 | {drained, timeout, overflow, space available} |
| devReq | output | 1 | Permission request to the peripheral |
| devGrant | input | 1 | Peripheral grants the request |
| devValid | output | 1 | Data on devData is valid |
| devData | output | DATA_W | Parallel data to the peripheral |
| devDone | input | 1 | Peripheral acknowledges receipt |

## Verification
Corruption of the FIFO pointers or level shows up at the data link as a word received out of order, duplicated or missing. It also shows up at once in `status` bit0 or bit3, the next cycle after the faulty write or pop. A wrong sequencer state appears within one cycle as `devValid` without a grant, or as `devReq` rising while the peripheral still holds its lines. A peripheral model flags both immediately. Faults in the wait counter appear as a timeout flag that is set when the peripheral answers in time, or missing when it stays silent. A word that survives or vanishes against the R7 rule is also a sign of this fault.

// File: rtl/pwp_pkg.sv
package pwp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ASK  = 2'd1,
    ST_SEND = 2'd2,
    ST_DROP = 2'd3
  } portState_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic pop;     // move head word into the output register
    logic cntRun;  // a wait on the peripheral is in progress
    logic cntClr;  // restart the wait counter
    logic setTo;   // record a timeout
  } ctlStrobe_t;

  localparam int STS_READY = 0;
  localparam int STS_OVF   = 1;
  localparam int STS_TO    = 2;
  localparam int STS_DRAIN = 3;
  localparam int STS_W     = 4;

endpackage

// File: rtl/pwp_datapath.sv
module pwp_datapath
  import pwp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int TO_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              stsClr,
  input  logic [TO_W-1:0]   toLimit,
  input  ctlStrobe_t        ctl,
  output logic [DATA_W-1:0] outData,
  output logic              bufEmpty,
  output logic              bufFull,
  output logic              toHit,
  output logic              ovfFlag,
  output logic              toFlag
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = PTR_W + 1;
  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [LVL_W-1:0]  level;
  logic [TO_W-1:0]   waitCnt;
  logic              wrAcc;
  logic              ovfEvt;

  assign bufEmpty = (level == '0);
  assign bufFull  = (level == LVL_MAX);
  assign wrAcc    = wrEn && !bufFull;
  assign ovfEvt   = wrEn && bufFull;

  // storage
  always_ff @(posedge clk) begin
    if (wrAcc) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (wrAcc) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (ctl.pop) rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      case ({wrAcc, ctl.pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // output holding register, loaded on grant
  always_ff @(posedge clk) begin
    if (!rstN) outData <= '0;
    else if (ctl.pop) outData <= mem[rdPtr];
  end

  // wait counter
  always_ff @(posedge clk) begin
    if (!rstN || ctl.cntClr) waitCnt <= '0;
    else if (ctl.cntRun && waitCnt != '1) waitCnt <= waitCnt + 1'b1;
  end

  assign toHit = ctl.cntRun && (toLimit != '0) && (waitCnt >= toLimit - 1'b1);

  // sticky flags, new event wins over clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
      toFlag  <= 1'b0;
    end else begin
      if (ovfEvt)      ovfFlag <= 1'b1;
      else if (stsClr) ovfFlag <= 1'b0;
      if (ctl.setTo)   toFlag  <= 1'b1;
      else if (stsClr) toFlag  <= 1'b0;
    end
  end

  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pop |-> !bufEmpty) else $error("pop from empty buffer"); // R5

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && bufFull && !ctl.pop) |=> (level == $past(level))) else $error("write into full buffer"); // R6

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !stsClr) |=> ovfFlag) else $error("overflow flag lost"); // R8

endmodule

// File: rtl/pwp_control.sv
module pwp_control
  import pwp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bufEmpty,
  input  logic       toHit,
  input  logic       devGrant,
  input  logic       devDone,
  output ctlStrobe_t ctl,
  output logic       devReq,
  output logic       devValid,
  output logic       portIdle
);

  portState_t state, nextState;

  always_comb begin
    nextState = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: begin
        if (!bufEmpty) nextState = ST_ASK;
      end
      ST_ASK: begin
        ctl.cntRun = 1'b1;
        if (devGrant) begin
          ctl.pop   = 1'b1;
          nextState = ST_SEND;
        end else if (toHit) begin
          ctl.setTo = 1'b1;
          nextState = ST_DROP;   // word stays buffered
        end
      end
      ST_SEND: begin
        ctl.cntRun = 1'b1;
        if (devDone) begin
          nextState = ST_DROP;
        end else if (toHit) begin
          ctl.setTo = 1'b1;
          nextState = ST_DROP;   // popped word is abandoned
        end
      end
      ST_DROP: begin
        ctl.cntRun = 1'b1;
        if (!devGrant && !devDone) begin
          nextState = ST_IDLE;
        end else if (toHit) begin
          ctl.setTo = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
    ctl.cntClr = (nextState != state);
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign devReq   = (state == ST_ASK) || (state == ST_SEND);
  assign devValid = (state == ST_SEND);
  assign portIdle = (state == ST_IDLE);

  AST_VALID_UNDER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    devValid |-> devReq) else $error("valid without request"); // R2

  AST_VALID_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(devValid) |-> $past(devGrant)) else $error("valid without grant"); // R2

  AST_HOLD_UNTIL_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DROP && (devGrant || devDone) && !toHit) |=> !devReq) else $error("request before release"); // R4

  AST_TIMEOUT_WITHDRAWS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ASK && !devGrant && toHit) |=> !devReq) else $error("request kept after timeout"); // R7

endmodule

// File: rtl/periph_wr_port.sv
module periph_wr_port
  import pwp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int TO_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              stsClr,
  input  logic [TO_W-1:0]   toLimit,
  output logic [3:0]        status,
  output logic              devReq,
  input  logic              devGrant,
  output logic              devValid,
  output logic [DATA_W-1:0] devData,
  input  logic              devDone
);

  ctlStrobe_t ctl;
  logic bufEmpty, bufFull, toHit, ovfFlag, toFlag, portIdle;

  pwp_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .TO_W(TO_W)) i_datapath (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .stsClr(stsClr),
    .toLimit(toLimit), .ctl(ctl), .outData(devData), .bufEmpty(bufEmpty),
    .bufFull(bufFull), .toHit(toHit), .ovfFlag(ovfFlag), .toFlag(toFlag)
  );

  pwp_control i_control (
    .clk(clk), .rstN(rstN), .bufEmpty(bufEmpty), .toHit(toHit),
    .devGrant(devGrant), .devDone(devDone), .ctl(ctl), .devReq(devReq),
    .devValid(devValid), .portIdle(portIdle)
  );

  always_comb begin
    status            = '0;
    status[STS_READY] = !bufFull;
    status[STS_OVF]   = ovfFlag;
    status[STS_TO]    = toFlag;
    status[STS_DRAIN] = bufEmpty && portIdle;
  end

  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (devValid && $past(devValid)) |-> $stable(devData)) else $error("data moved in data phase"); // R3

endmodule

// File: tb/test_periph_wr_port.sv
`timescale 1ns/1ps
module test_periph_wr_port;

  localparam int DW = 8;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic stsClr = 1'b0;
  logic [TW-1:0] toLimit = '0;
  logic [3:0] status;
  logic devReq, devValid;
  logic devGrant = 1'b0;
  logic devDone = 1'b0;
  logic [DW-1:0] devData;

  periph_wr_port #(.DATA_W(DW), .DEPTH(4), .TO_W(TW)) i_periph_wr_port (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .stsClr(stsClr),
    .toLimit(toLimit), .status(status), .devReq(devReq), .devGrant(devGrant),
    .devValid(devValid), .devData(devData), .devDone(devDone)
  );

  always #4 clk = ~clk;  // 125 MHz

  int nChecks = 0;
  int nBad = 0;

  // peripheral model controls and observations
  bit periphOn = 1'b0;
  int grantDly = 0, doneDly = 0, holdDly = 0;
  logic [DW-1:0] recv [64];
  int nRecv = 0;
  int protoBad = 0, stabBad = 0, releaseBad = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // peripheral: drives at negedge, samples there as well
  initial begin
    int ps = 0, pc = 0;
    bit seen = 0, dropped = 0;
    logic [DW-1:0] cap = '0;
    forever begin
      @(negedge clk);
      if (devValid && !devReq) protoBad++;
      case (ps)
        0: begin
          if (devValid) protoBad++;
          if (periphOn && devReq) begin
            if (pc >= grantDly) begin devGrant = 1'b1; ps = 1; pc = 0; seen = 0; end
            else pc++;
          end else pc = 0;
        end
        1: begin
          if (!devReq) begin
            devGrant = 1'b0; ps = 0; pc = 0; seen = 0;
          end else if (devValid) begin
            if (!seen) begin seen = 1; cap = devData; end
            else if (devData != cap) stabBad++;
            if (pc >= doneDly) begin
              recv[nRecv] = devData; nRecv++;
              devDone = 1'b1; ps = 2; pc = 0; dropped = 0;
            end else pc++;
          end
        end
        default: begin
          if (!devReq) dropped = 1;
          else if (dropped) releaseBad++;
          if (dropped) begin
            if (pc >= holdDly) begin
              devGrant = 1'b0; devDone = 1'b0; ps = 0; pc = 0;
            end else pc++;
          end
        end
      endcase
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [DW-1:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic clrSts();
    @(negedge clk); stsClr = 1'b1;
    @(negedge clk); stsClr = 1'b0;
  endtask

  task automatic waitRecv(input int n);
    for (int i = 0; i < 3000 && nRecv < n; i++) @(negedge clk);
  endtask

  task automatic waitDrain();
    for (int i = 0; i < 3000 && status[3] !== 1'b1; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    cyc(1);
    check(status == 4'b1001, "R1 status", status, 4'b1001);
    check(devReq == 0 && devValid == 0, "R1 lines", {devReq, devValid}, 0);
  endtask

  task automatic t_single();
    periphOn = 1; grantDly = 0; doneDly = 0; holdDly = 0;
    wr(8'hA5);
    check(status[3] == 0, "R9 busy", status[3], 0);
    waitRecv(1);
    check(nRecv == 1 && recv[0] == 8'hA5, "R3 single word", recv[0], 8'hA5);
    waitDrain();
    check(status == 4'b1001 && !devReq, "R9 drained", status, 4'b1001);
  endtask

  task automatic t_burst_overflow();
    int base;
    base = nRecv;
    grantDly = 5; doneDly = 7;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); wrEn = 1'b1; wrData = 8'h10 + 8'(i);
    end
    @(negedge clk); wrEn = 1'b0;
    check(status[0] == 0, "R5 full", status[0], 0);
    wr(8'hEE);
    check(status[1] == 1, "R6 overflow set", status[1], 1);
    waitRecv(base + 4);
    waitDrain();
    cyc(20);
    check(nRecv == base + 4, "R6 dropped word absent", nRecv - base, 4);
    for (int i = 0; i < 4; i++)
      check(recv[base + i] == 8'h10 + 8'(i), "R3 order", recv[base + i], 8'h10 + i);
    check(status[1] == 1, "R6 sticky", status[1], 1);
    check(status[0] == 1, "R5 space again", status[0], 1);
  endtask

  task automatic t_clear();
    clrSts();
    check(status[2:1] == 2'b00, "R8 clear", status[2:1], 0);
  endtask

  task automatic t_release_hold();
    int base;
    base = nRecv;
    grantDly = 0; doneDly = 1; holdDly = 6;
    wr(8'h31); wr(8'h32);
    waitRecv(base + 2);
    waitDrain();
    check(nRecv == base + 2 && recv[base + 1] == 8'h32, "R4 next word after release", recv[base + 1], 8'h32);
    check(releaseBad == 0, "R4 request before release", releaseBad, 0);
    holdDly = 0;
  endtask

  task automatic t_timeout_ask();
    int base;
    base = nRecv;
    periphOn = 0; toLimit = 10;
    wr(8'h55);
    cyc(40);
    check(status[2] == 1, "R7 grant timeout", status[2], 1);
    toLimit = 0;
    cyc(25);
    clrSts();
    periphOn = 1; grantDly = 0; doneDly = 0;
    waitRecv(base + 1);
    check(nRecv == base + 1 && recv[base] == 8'h55, "R7 word kept", recv[base], 8'h55);
    check(status[2] == 0, "R7 zero limit no timeout", status[2], 0);
    waitDrain();
  endtask

  task automatic t_timeout_send();
    int base;
    base = nRecv;
    toLimit = 10; grantDly = 0; doneDly = 1000;
    wr(8'h66);
    cyc(40);
    check(status[2] == 1, "R7 data timeout", status[2], 1);
    waitDrain();
    toLimit = 0; doneDly = 0;
    clrSts();
    wr(8'h77);
    waitRecv(base + 1);
    waitDrain();
    check(nRecv == base + 1 && recv[base] == 8'h77, "R7 data word discarded", recv[base], 8'h77);
  endtask

  task automatic t_clear_collide();
    int base;
    base = nRecv;
    periphOn = 0; toLimit = 0;
    clrSts();
    for (int i = 0; i < 4; i++) wr(8'h80 + 8'(i));
    check(status[1:0] == 2'b00, "R5 full no ovf", status[1:0], 0);
    @(negedge clk); wrEn = 1'b1; wrData = 8'hFF; stsClr = 1'b1;
    @(negedge clk); wrEn = 1'b0; stsClr = 1'b0;
    check(status[1] == 1, "R8 set wins", status[1], 1);
    clrSts();
    check(status[1] == 0, "R8 clear alone", status[1], 0);
    periphOn = 1;
    waitRecv(base + 4);
    waitDrain();
    check(nRecv == base + 4 && recv[base + 3] == 8'h83, "R6 collide drain", recv[base + 3], 8'h83);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", nChecks + 1, nBad);
    $finish;
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    t_reset();
    t_single();
    t_burst_overflow();
    t_clear();
    t_release_hold();
    t_timeout_ask();
    t_timeout_send();
    t_clear_collide();
    check(protoBad == 0, "R2 valid only after grant under request", protoBad, 0);
    check(stabBad == 0, "R3 data stable", stabBad, 0);
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule